// File: doc/BRIEF.md
# Single-Line Thermometer Read Bridge

This block performs one complete temperature read on a three-wire sensor. The sensor has a clock, an active-high enable and a single bidirectional data line. The host gives a one-cycle request. The bridge then raises the enable and clocks out the fixed read command, least significant bit first. It hands the data line over to the sensor and clocks in the 9-bit reading, also least significant bit first. It drops the enable after the last clock and presents the reading in normal bit order, together with a one-cycle valid pulse.

The sensor clock comes from the system clock through a half-period divider. While the bridge drives the data line, the direction output is low. While the sensor drives it, the direction output is high, which lets an external buffer follow the ownership of the line. A shared read-back line carries the sensor data only while an access owns the bus. At all other times that line is released, so other devices on it are not disturbed.

Top module: `thermo_bridge`

## Requirements
- R1: While rst_n is low at a clock edge, the outputs after that edge are: sens_en_o=0, sens_clk_o=0, sens_dir_o=0, temp_vld_o=0, temp_o=0.
- R2: A high start_i in an idle cycle raises sens_en_o after the next edge. The data line then carries command bit 0 for HALF cycles with sens_clk_o low before the first rising clock.
- R3: The command code (default 0xAA) goes out over 8 sensor clocks, bit 0 first. Each bit is driven for a low half and a high half of HALF system cycles each, and the sensor samples it on the rising sensor clock. sens_clk_o rests low whenever sens_en_o is low.
- R4: After the falling sensor clock that ends the eighth command bit, there is exactly one system cycle with sens_dir_o high, sens_clk_o low and the bridge not driving the line.
- R5: The response phase has 16 sensor clocks. The bridge samples the line on each rising edge. The first 9 samples form temp_o with the first sample in bit 0. The last 7 samples are ignored.
- R6: sens_en_o stays high from the request through the falling edge of the 16th response clock, and then goes low.
- R7: temp_vld_o is high for exactly the one cycle in which sens_en_o first reads low after an access. temp_o changes only together with that pulse.
- R8: start_i is ignored while an access is in progress. A start_i high in the same cycle as the temp_vld_o pulse begins a new access.
- R9: miso_o follows the data line while sens_en_o and sens_dir_o are both high. It is high-impedance whenever sens_en_o is low.
- R10: sens_dir_o is low whenever sens_en_o is low. It is high only from the turnaround cycle to the end of the response.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Read request, sampled in idle cycles |
| sens_clk_o | output | 1 | Sensor shift clock, rests low |
| sens_en_o | output | 1 | Sensor enable, active high, spans the whole access |
| sens_dir_o | output | 1 | Line direction: 0 towards sensor, 1 from sensor |
| sens_dq_io | inout | 1 | Bidirectional sensor data line |
| miso_o | output | 1 | Shared read-back of the data line, released when idle |
| temp_o | output | 9 | Last reading, normal bit order |
| temp_vld_o | output | 1 | One-cycle pulse when temp_o is updated |

## Verification
The sensor is a behavioural model that answers several readings. A reading of only bit 0 and a reading of only bit 8 together show whether the response is reversed or shifted by one. All ones and all zeros, checked against dummy clocks that return ones, show whether samples beyond the ninth leak into the result. Extra requests in the middle of an access are checked against a timeline that must stay unchanged. A request held high across several accesses shows that the valid cycle is the earliest point at which a new access can begin. The bench compares every output in every cycle, and the command bits captured by the sensor model expose any wrong bit order or clock phase on the outgoing side.

// File: rtl/thermo_bridge_pkg.sv
// Shared constants and phase encoding for the thermometer read bridge.
// Assumes a fixed read transaction: one command byte, then a padded response.
package thermo_bridge_pkg;
    localparam int CMD_W      = 8;
    localparam int RESP_W     = 9;
    localparam int RESP_CLKS  = 16;
    localparam int CIW        = $clog2(CMD_W);
    localparam int BCW        = $clog2(RESP_CLKS);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_CMD,
        PH_GUARD,
        PH_RESP
    } phase_t;
endpackage

// File: rtl/thb_bitrev.sv
// Reverses the bit order of a word; purely combinational wiring.
// Assumes nothing beyond W >= 1.
module thb_bitrev #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign out_o[i] = in_i[W-1-i];
    end
endmodule

// File: rtl/thb_halfclk.sv
// Half-period timer: pulses tick_o every HALF cycles while run_i is high.
// Assumes the counter restarts from zero whenever run_i drops.
module thb_halfclk #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == CW'(HALF - 1));

    // Count system cycles inside one half of the sensor clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || tick_o) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/thb_seq.sv
// Access sequencer: setup, command, turnaround, response, then result.
// Assumes tick_i marks the end of each sensor clock half-period.
// The response is shifted in first-bit-at-MSB; reversal is done outside.
module thb_seq
    import thermo_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic              dq_i,
    output logic              run_o,
    output logic              sclk_o,
    output logic              en_o,
    output logic              dir_o,
    output logic              drv_o,
    output logic [CIW-1:0]    cmd_idx_o,
    output logic [RESP_W-1:0] raw_o,
    output logic              vld_o
);
    phase_t            ph_q;
    logic [BCW-1:0]    bit_q;
    logic [RESP_W-1:0] sh_q;
    logic [RESP_W-1:0] hold_q;
    logic              sclk_q;
    logic              vld_q;

    // Decode the line controls from the phase.
    always_comb begin
        run_o = (ph_q == PH_SETUP) || (ph_q == PH_CMD) || (ph_q == PH_RESP);
        en_o  = (ph_q != PH_IDLE);
        dir_o = (ph_q == PH_GUARD) || (ph_q == PH_RESP);
        drv_o = (ph_q == PH_SETUP) || (ph_q == PH_CMD);
    end

    assign sclk_o    = sclk_q;
    assign vld_o     = vld_q;
    assign raw_o     = hold_q;
    assign cmd_idx_o = bit_q[CIW-1:0];

    // Advance the access phases and shift the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            bit_q  <= '0;
            sh_q   <= '0;
            hold_q <= '0;
            sclk_q <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            unique case (ph_q)
                PH_IDLE: begin
                    if (start_i) begin
                        ph_q  <= PH_SETUP;
                        bit_q <= '0;
                    end
                end
                PH_SETUP: begin
                    if (tick_i) ph_q <= PH_CMD;
                end
                PH_CMD: begin
                    if (tick_i) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (bit_q == BCW'(CMD_W - 1)) begin
                                ph_q  <= PH_GUARD;
                                bit_q <= '0;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end
                end
                PH_GUARD: begin
                    ph_q <= PH_RESP;
                end
                PH_RESP: begin
                    if (tick_i) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            if (bit_q < BCW'(RESP_W)) sh_q <= {sh_q[RESP_W-2:0], dq_i};
                        end else begin
                            sclk_q <= 1'b0;
                            if (bit_q == BCW'(RESP_CLKS - 1)) begin
                                ph_q   <= PH_IDLE;
                                bit_q  <= '0;
                                hold_q <= sh_q;
                                vld_q  <= 1'b1;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/thermo_bridge.sv
// Top of the thermometer read bridge: timer, sequencer, bit-order networks
// and the tri-state line drivers. Assumes an external weak pull on the line.
module thermo_bridge
    import thermo_bridge_pkg::*;
#(
    parameter int          HALF     = 2,
    parameter logic [7:0]  CMD_CODE = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              sens_clk_o,
    output logic              sens_en_o,
    output logic              sens_dir_o,
    inout  wire               sens_dq_io,
    output logic              miso_o,
    output logic [RESP_W-1:0] temp_o,
    output logic              temp_vld_o
);
    logic              run, tick, drv, dq_bit;
    logic [CIW-1:0]    cmd_idx, ridx;
    logic [CMD_W-1:0]  cmd_rev;
    logic [RESP_W-1:0] raw;

    thb_halfclk #(.HALF(HALF)) u_half (
        .clk(clk), .rst_n(rst_n), .run_i(run), .tick_o(tick)
    );

    thb_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick),
        .dq_i(sens_dq_io), .run_o(run), .sclk_o(sens_clk_o),
        .en_o(sens_en_o), .dir_o(sens_dir_o), .drv_o(drv),
        .cmd_idx_o(cmd_idx), .raw_o(raw), .vld_o(temp_vld_o)
    );

    // Command goes out as a host-order word sent from its reversed MSB end.
    thb_bitrev #(.W(CMD_W)) u_cmd_rev (.in_i(CMD_CODE), .out_o(cmd_rev));
    // Response arrives first-bit-high; reverse it into normal order.
    thb_bitrev #(.W(RESP_W)) u_resp_rev (.in_i(raw), .out_o(temp_o));

    assign ridx       = CIW'(CMD_W - 1) - cmd_idx;
    assign dq_bit     = cmd_rev[ridx];
    assign sens_dq_io = drv ? dq_bit : 1'bz;
    assign miso_o     = (sens_en_o && sens_dir_o) ? sens_dq_io : 1'bz;
endmodule

// File: rtl/thermo_bridge_chk.sv
// Protocol checker for the thermometer read bridge, bound to the top.
// Assumes it observes only the top-level ports.
module thermo_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sens_en_o,
    input logic       sens_dir_o,
    input logic       sens_clk_o,
    input logic       temp_vld_o,
    input logic [8:0] temp_o
);
    p_dir_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sens_dir_o |-> sens_en_o);

    p_clk_rests_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sens_en_o |-> !sens_clk_o);

    p_turnaround_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sens_dir_o) |-> !sens_clk_o);

    p_end_marks_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sens_en_o) |-> temp_vld_o);

    p_valid_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        temp_vld_o |=> !temp_vld_o);

    p_valid_while_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        temp_vld_o |-> !sens_en_o);

    p_result_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_vld_o |-> $stable(temp_o));
endmodule

bind thermo_bridge thermo_bridge_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sens_en_o(sens_en_o), .sens_dir_o(sens_dir_o),
    .sens_clk_o(sens_clk_o), .temp_vld_o(temp_vld_o), .temp_o(temp_o)
);

// File: tb/thermo_bridge_tb_top.sv
// Bench: cycle-by-cycle timeline model plus a behavioural sensor.
module thermo_bridge_tb_top;
    localparam int         CLK_PERIOD = 10;
    localparam int         HALF       = 2;
    localparam logic [7:0] CMD        = 8'hAA;
    localparam int         T_GUARD    = 17 * HALF;
    localparam int         T_END      = 49 * HALF + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    wire        sclk, en, dir, vld;
    wire  [8:0] temp;
    tri         dq_w;
    tri         miso_w;

    pulldown (dq_w);
    pullup (miso_w);

    logic       s_drv = 1'b0;
    logic       s_bit = 1'b0;
    assign dq_w = s_drv ? s_bit : 1'bz;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermo_bridge #(.HALF(HALF), .CMD_CODE(CMD)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sens_clk_o(sclk),
        .sens_en_o(en), .sens_dir_o(dir), .sens_dq_io(dq_w), .miso_o(miso_w),
        .temp_o(temp), .temp_vld_o(vld)
    );

    int         n_chk = 0;
    int         n_bad = 0;
    bit         busy = 0;
    int         mc = 0;
    bit         ign = 0;
    logic [8:0] s_val = '0;
    logic [8:0] m_val = '0;
    logic [8:0] e_temp = '0;
    logic [7:0] s_cmd = '0;
    int         s_rises = 0;
    logic       s_prev = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // One cycle: update the model for the last edge, compare, move the sensor.
    task automatic step();
        bit    e_en, e_vld, e_dir, e_sclk, e_drv, e_bit;
        string tag;
        @(negedge clk);
        if (!rst_n) begin
            busy = 0; e_temp = '0;
        end else begin
            if (busy && mc == T_END) busy = 0;
            if (!busy && start) begin
                busy = 1; mc = 0; m_val = s_val;
            end else if (busy) begin
                mc++;
                if (mc == T_END) e_temp = m_val;
            end
        end
        e_en  = busy && mc < T_END;
        e_vld = busy && mc == T_END;
        e_dir = busy && mc >= T_GUARD && mc < T_END;
        e_drv = busy && mc < T_GUARD;
        e_sclk = 1'b0;
        if (busy && mc >= HALF && mc < T_GUARD)
            e_sclk = ((mc - HALF) % (2*HALF)) >= HALF;
        else if (busy && mc > T_GUARD && mc < T_END)
            e_sclk = ((mc - T_GUARD - 1) % (2*HALF)) >= HALF;
        e_bit = (mc < HALF) ? CMD[0] : CMD[(mc - HALF) / (2*HALF)];
        if (!rst_n)                  tag = "R1";
        else if (ign)                tag = "R8";
        else if (!busy)              tag = "R6";
        else if (mc < HALF)          tag = "R2";
        else if (mc < T_GUARD)       tag = "R3";
        else if (mc == T_GUARD)      tag = "R4";
        else if (mc < T_END)         tag = "R5";
        else                         tag = "R7";
        chk(tag, "sens_en", int'(en), int'(e_en));
        chk(tag, "sens_dir R10", int'(dir), int'(e_dir));
        chk(tag, "sens_clk", int'(sclk), int'(e_sclk));
        chk(rst_n ? "R7" : "R1", "temp_vld", int'(vld), int'(e_vld));
        chk(rst_n ? "R5" : "R1", "temp", int'(temp), int'(e_temp));
        if (e_drv) chk("R3", "dq command bit", int'(dq_w === 1'b1), int'(e_bit));
        if (!e_en) chk("R9", "miso released", int'(miso_w === 1'b1), 1);
        else if (e_dir && s_drv) chk("R9", "miso follows line", int'(miso_w === 1'b1), int'(s_bit));
        if (e_vld) chk("R3", "command at sensor", int'(s_cmd), int'(CMD));
        // Sensor model: sample on rising clock, drive on falling after command.
        if (!en) begin
            s_rises = 0; s_drv = 1'b0; s_prev = 1'b0;
        end else begin
            if (!s_prev && sclk) begin
                if (s_rises < 8) s_cmd[s_rises] = (dq_w === 1'b1);
                s_rises++;
            end
            if (s_prev && !sclk && s_rises >= 8) begin
                s_drv = 1'b1;
                s_bit = (s_rises - 8 < 9) ? s_val[s_rises - 8] : 1'b1;
            end
            s_prev = sclk;
        end
    endtask

    task automatic access(input logic [8:0] v);
        s_val = v;
        start = 1'b1; step(); start = 1'b0;
        repeat (T_END + 4) step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        repeat (3) step();
        access(9'h001);   // R5 LSB lands in bit 0
        access(9'h100);   // R5 ninth bit lands in bit 8
        access(9'h1FF);
        access(9'h000);   // R5 dummy ones must not leak in
        access(9'h155);
        access(9'h0C3);
        // R8: requests during an access are ignored
        ign = 1; s_val = 9'h12D;
        start = 1'b1; step(); start = 1'b0;
        repeat (30) step();
        start = 1'b1; step(); start = 1'b0;
        repeat (60) step();
        start = 1'b1; step(); start = 1'b0;
        repeat (T_END) step();
        ign = 0;
        // R8: request held high restarts in the valid cycle
        s_val = 9'h0F0;
        start = 1'b1;
        repeat (2 * (T_END + 1)) step();
        start = 1'b0;
        repeat (T_END + 4) step();
        summary();
        $finish;
    end
endmodule